// File: doc/BRIEF.md
# Dual Front-End Shared Core Allocator

This block places two independent command front-ends in front of one shared pool of execution slots. Each front-end reads its own command stream. It accepts DISPATCH, FLUSH, NOP and END commands once its start pulse has arrived, and it keeps a private queue of threads waiting to launch. A DISPATCH carries a tag, a thread count and a run length in cycles. Each thread of a dispatch occupies one slot for exactly that many cycles and then retires.

In every cycle, a single allocator hands the currently free slots to the two queues. When only one queue is holding threads, that queue takes as many slots as it can use. When both queues are holding threads, the free slots are split in half. An odd slot left over goes to each queue in turn. Any share that one queue cannot fill passes to the other queue, so the other stream can use slots left idle by a small dispatch or by a barrier wait. A FLUSH stops only its own stream, until every thread of that stream has retired. Each slot records which queue owns it, so each retirement is counted against the correct stream. Each stream raises an idle flag once it has ended and has no threads left.

Top module: `dual_fe_alloc`

## Requirements
- R1: Command opcodes are 0 = NOP, 1 = DISPATCH, 2 = FLUSH and 3 = END. A stream consumes nothing before its start pulse. Once running, a stream consumes a NOP, FLUSH or END in the cycle it is presented. It consumes a DISPATCH only in a cycle where its queue holds no waiting threads.
- R2: When only one queue holds threads, it is granted min(waiting, free) slots. Granted slots are the lowest-numbered free slots, and queue 0's grants take the lower indices before queue 1's.
- R3: When both queues hold threads, each queue's share is half of the free slots. Any part of a share that a queue cannot use goes to the other queue. No free slot stays idle while threads are waiting for it.
- R4: When both queues hold threads and the free count is odd, the extra slot alternates between the queues. Queue 0 receives it first after reset.
- R5: A dispatch accepted in cycle t shows busy slots from cycle t+2. Each thread keeps its slot for its run length in cycles, and a run length of 0 counts as 1. A slot can be granted again in the cycle after its thread retires. N threads on an otherwise empty pool therefore finish in ceil(N/16)*(L+1)+1 cycles after acceptance.
- R6: A FLUSH holds only its own stream, until all threads that stream has accepted so far have retired. The other stream keeps launching threads during that wait.
- R7: Each cycle, retireN reports how many slots owned by queue N finish their run in that cycle.
- R8: idleN is high exactly when stream N has consumed END and has no waiting or running threads.
- R9: After reset, all slots are free, no command is consumed and both idle flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start0 | input | 1 | Begin reading stream 0 |
| cmd0_op | input | 2 | Stream 0 opcode |
| cmd0_tag | input | TAGW | Stream 0 dispatch tag |
| cmd0_cnt | input | CNTW | Stream 0 thread count |
| cmd0_len | input | LENW | Stream 0 run length |
| cmd0_take | output | 1 | Stream 0 command consumed this cycle |
| start1 | input | 1 | Begin reading stream 1 |
| cmd1_op | input | 2 | Stream 1 opcode |
| cmd1_tag | input | TAGW | Stream 1 dispatch tag |
| cmd1_cnt | input | CNTW | Stream 1 thread count |
| cmd1_len | input | LENW | Stream 1 run length |
| cmd1_take | output | 1 | Stream 1 command consumed this cycle |
| slot_busy | output | NSLOT | Slot holds a running thread |
| slot_owner | output | NSLOT | Queue owning each slot (1 = queue 1) |
| slot_tag | output | NSLOT*TAGW | Tag of the dispatch running in each slot |
| retire0 | output | $clog2(NSLOT+1) | Queue 0 threads finishing this cycle |
| retire1 | output | $clog2(NSLOT+1) | Queue 1 threads finishing this cycle |
| idle0 | output | 1 | Stream 0 ended and drained |
| idle1 | output | 1 | Stream 1 ended and drained |

## Verification
Two situations can occur in the same cycle. In the first, slots free up while both queues hold threads, and the free count is odd. The bench creates this by having one stream pin a single slot with a long thread while two streams of short threads refill the rest. It then compares each queue's slot count on two successive refills against the alternating split. In the second, one stream's flush release coincides with the other stream still launching threads. The bench confirms that the post-barrier dispatch is consumed only after all sixteen earlier threads of its stream have retired, and that the other queue held slots during the wait.

// File: rtl/dual_fe_alloc.sv
module dual_fe_alloc #(
  parameter int NSLOT = 16,
  parameter int TAGW  = 4,
  parameter int CNTW  = 8,
  parameter int LENW  = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start0,
  input  logic [1:0]                 cmd0_op,
  input  logic [TAGW-1:0]            cmd0_tag,
  input  logic [CNTW-1:0]            cmd0_cnt,
  input  logic [LENW-1:0]            cmd0_len,
  output logic                       cmd0_take,
  input  logic                       start1,
  input  logic [1:0]                 cmd1_op,
  input  logic [TAGW-1:0]            cmd1_tag,
  input  logic [CNTW-1:0]            cmd1_cnt,
  input  logic [LENW-1:0]            cmd1_len,
  output logic                       cmd1_take,
  output logic [NSLOT-1:0]           slot_busy,
  output logic [NSLOT-1:0]           slot_owner,
  output logic [NSLOT*TAGW-1:0]      slot_tag,
  output logic [$clog2(NSLOT+1)-1:0] retire0,
  output logic [$clog2(NSLOT+1)-1:0] retire1,
  output logic                       idle0,
  output logic                       idle1
);
  localparam int SW = $clog2(NSLOT+1);
  localparam int OW = CNTW + 1;
  localparam logic [1:0] OP_DISP = 2'd1, OP_FLUSH = 2'd2, OP_END = 2'd3;

  typedef enum logic [1:0] {S_OFF, S_RUN, S_WAIT, S_END} st_t;

  logic [1:0]      op   [2];
  logic [TAGW-1:0] itag [2];
  logic [CNTW-1:0] icnt [2];
  logic [LENW-1:0] ilen [2];
  logic [1:0]      go;

  assign op[0] = cmd0_op;   assign op[1] = cmd1_op;
  assign itag[0] = cmd0_tag; assign itag[1] = cmd1_tag;
  assign icnt[0] = cmd0_cnt; assign icnt[1] = cmd1_cnt;
  assign ilen[0] = cmd0_len; assign ilen[1] = cmd1_len;
  assign go = {start1, start0};

  st_t                  st   [2];
  logic [1:0][CNTW-1:0] pend;
  logic [1:0][OW-1:0]   outs, grant;
  logic [TAGW-1:0]      ctag [2];
  logic [LENW-1:0]      clen [2];
  logic [1:0]           take, load, wait_q;
  logic                 tb;

  logic [NSLOT-1:0] busy, owner, give, gown;
  logic [LENW-1:0]  rem  [NSLOT];
  logic [TAGW-1:0]  stag [NSLOT];
  logic [SW-1:0]    nfree;
  logic [1:0][SW-1:0] ret;

  always_comb begin
    nfree = '0;
    ret   = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (!busy[i]) nfree = nfree + SW'(1);
      else if (rem[i] == LENW'(1)) ret[owner[i]] = ret[owner[i]] + SW'(1);
    end
  end

  logic          both;
  logic [OW-1:0] p0, p1, fr, sh0, sh1, spare1, lim0, rest;
  assign p0     = OW'(pend[0]);
  assign p1     = OW'(pend[1]);
  assign both   = (p0 != '0) && (p1 != '0);
  assign fr     = OW'(nfree);
  assign sh0    = both ? (fr >> 1) + OW'(fr[0] & ~tb) : fr;
  assign sh1    = fr - sh0;
  assign spare1 = (both && p1 < sh1) ? sh1 - p1 : '0;
  assign lim0   = sh0 + spare1;
  assign grant[0] = (p0 < lim0) ? p0 : lim0;
  assign rest   = fr - grant[0];
  assign grant[1] = (p1 < rest) ? p1 : rest;

  always_comb begin
    int rank;
    rank = 0;
    give = '0;
    gown = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (!busy[i]) begin
        if (rank < int'(grant[0])) give[i] = 1'b1;
        else if (rank < int'(grant[0]) + int'(grant[1])) begin
          give[i] = 1'b1;
          gown[i] = 1'b1;
        end
        rank++;
      end
    end
  end

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      take[s]   = (st[s] == S_RUN) && (op[s] != OP_DISP || pend[s] == '0);
      load[s]   = take[s] && op[s] == OP_DISP;
      wait_q[s] = (st[s] == S_WAIT);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tb   <= 1'b0;
      pend <= '0;
      outs <= '0;
      for (int s = 0; s < 2; s++) begin
        st[s]   <= S_OFF;
        ctag[s] <= '0;
        clen[s] <= '0;
      end
    end else begin
      if (both && nfree[0]) tb <= ~tb;
      for (int s = 0; s < 2; s++) begin
        pend[s] <= pend[s] - CNTW'(grant[s]) + (load[s] ? icnt[s] : '0);
        outs[s] <= outs[s] - OW'(ret[s]) + (load[s] ? OW'(icnt[s]) : '0);
        if (load[s]) begin
          ctag[s] <= itag[s];
          clen[s] <= (ilen[s] == '0) ? LENW'(1) : ilen[s];
        end
        case (st[s])
          S_OFF, S_END: if (go[s]) st[s] <= S_RUN;
          S_RUN: if (take[s]) begin
            if (op[s] == OP_FLUSH) st[s] <= S_WAIT;
            else if (op[s] == OP_END) st[s] <= S_END;
          end
          S_WAIT: if (outs[s] == '0) st[s] <= S_RUN;
          default: st[s] <= S_OFF;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= '0;
      owner <= '0;
      for (int i = 0; i < NSLOT; i++) begin
        rem[i]  <= '0;
        stag[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NSLOT; i++) begin
        if (give[i]) begin
          busy[i]  <= 1'b1;
          owner[i] <= gown[i];
          rem[i]   <= clen[gown[i]];
          stag[i]  <= ctag[gown[i]];
        end else if (busy[i]) begin
          if (rem[i] == LENW'(1)) busy[i] <= 1'b0;
          else rem[i] <= rem[i] - LENW'(1);
        end
      end
    end
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_tag
    assign slot_tag[i*TAGW +: TAGW] = stag[i];
  end

  assign slot_busy  = busy;
  assign slot_owner = owner;
  assign cmd0_take  = take[0];
  assign cmd1_take  = take[1];
  assign retire0    = ret[0];
  assign retire1    = ret[1];
  assign idle0      = (st[0] == S_END) && (outs[0] == '0);
  assign idle1      = (st[1] == S_END) && (outs[1] == '0);
endmodule

// File: rtl/dual_fe_alloc_chk.sv
module dual_fe_alloc_chk #(
  parameter int NSLOT = 16,
  parameter int CNTW  = 8,
  parameter int OW    = 9,
  parameter int SW    = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0][CNTW-1:0] pend,
  input logic [1:0][OW-1:0]   grant,
  input logic [SW-1:0]        nfree,
  input logic [1:0]           wait_q,
  input logic [1:0]           take,
  input logic [1:0]           idle,
  input logic [NSLOT-1:0]     busy,
  input logic [NSLOT-1:0]     owner
);
  a_r2_grant_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(grant[0]) <= int'(pend[0]) && int'(grant[1]) <= int'(pend[1]) &&
    int'(grant[0]) + int'(grant[1]) <= int'(nfree));

  a_r3_no_idle_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(pend[0]) + int'(pend[1]) >= int'(nfree)) |->
      (int'(grant[0]) + int'(grant[1]) == int'(nfree)));

  a_r3_even_split: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(pend[0]) >= NSLOT && int'(pend[1]) >= NSLOT) |->
      (int'(grant[0]) - int'(grant[1]) <= 1 && int'(grant[1]) - int'(grant[0]) <= 1));

  a_r6_hold_q0: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q[0] |-> !take[0]);

  a_r6_hold_q1: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q[1] |-> !take[1]);

  a_r8_idle_q0: assert property (@(posedge clk) disable iff (!rst_n)
    idle[0] |-> ((busy & ~owner) == '0));

  a_r8_idle_q1: assert property (@(posedge clk) disable iff (!rst_n)
    idle[1] |-> ((busy & owner) == '0));
endmodule

bind dual_fe_alloc dual_fe_alloc_chk #(.NSLOT(NSLOT), .CNTW(CNTW), .OW(OW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend(pend), .grant(grant), .nfree(nfree),
  .wait_q(wait_q), .take(take), .idle({idle1, idle0}), .busy(busy), .owner(owner)
);

// File: tb/tb_dual_fe_alloc.sv
module tb_dual_fe_alloc;
  localparam int NSLOT = 16, TAGW = 4, CNTW = 8, LENW = 10;
  localparam int SW = $clog2(NSLOT+1);
  localparam logic [1:0] NOP = 2'd0, DISP = 2'd1, FLSH = 2'd2, ENDC = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0, start0 = 1'b0, start1 = 1'b0;
  logic [1:0] cmd0_op, cmd1_op;
  logic [TAGW-1:0] cmd0_tag, cmd1_tag;
  logic [CNTW-1:0] cmd0_cnt, cmd1_cnt;
  logic [LENW-1:0] cmd0_len, cmd1_len;
  logic cmd0_take, cmd1_take, idle0, idle1;
  logic [NSLOT-1:0] slot_busy, slot_owner;
  logic [NSLOT*TAGW-1:0] slot_tag;
  logic [SW-1:0] retire0, retire1;

  always #10 clk = ~clk;

  dual_fe_alloc #(.NSLOT(NSLOT), .TAGW(TAGW), .CNTW(CNTW), .LENW(LENW)) dut (
    .clk(clk), .rst_n(rst_n),
    .start0(start0), .cmd0_op(cmd0_op), .cmd0_tag(cmd0_tag), .cmd0_cnt(cmd0_cnt),
    .cmd0_len(cmd0_len), .cmd0_take(cmd0_take),
    .start1(start1), .cmd1_op(cmd1_op), .cmd1_tag(cmd1_tag), .cmd1_cnt(cmd1_cnt),
    .cmd1_len(cmd1_len), .cmd1_take(cmd1_take),
    .slot_busy(slot_busy), .slot_owner(slot_owner), .slot_tag(slot_tag),
    .retire0(retire0), .retire1(retire1), .idle0(idle0), .idle1(idle1));

  logic [1:0] pop [2][8];
  int pc [2][8];
  int pl [2][8];
  logic [2:0] idx [2];
  logic took [2];
  int cyc = 0, nchk = 0, nfail = 0, rt0 = 0, rt1 = 0;

  assign cmd0_op  = pop[0][idx[0]];
  assign cmd0_tag = TAGW'(idx[0]);
  assign cmd0_cnt = CNTW'(pc[0][idx[0]]);
  assign cmd0_len = LENW'(pl[0][idx[0]]);
  assign cmd1_op  = pop[1][idx[1]];
  assign cmd1_tag = TAGW'(idx[1]);
  assign cmd1_cnt = CNTW'(pc[1][idx[1]]);
  assign cmd1_len = LENW'(pl[1][idx[1]]);

  always @(posedge clk) cyc <= cyc + 1;

  always begin
    @(negedge clk);
    for (int s = 0; s < 2; s++)
      if (took[s] && idx[s] != 3'd7) idx[s] = idx[s] + 3'd1;
    #1;
    took[0] = cmd0_take;
    took[1] = cmd1_take;
  end

  always begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      rt0 = rt0 + int'(retire0);
      rt1 = rt1 + int'(retire1);
    end
  end

  task automatic step();
    @(negedge clk);
    #3;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int qcount(input int q);
    int n = 0;
    for (int i = 0; i < NSLOT; i++)
      if (slot_busy[i] && int'(slot_owner[i]) == q) n++;
    return n;
  endfunction

  task automatic clear_prog();
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 8; k++) begin
        pop[s][k] = NOP; pc[s][k] = 0; pl[s][k] = 1;
      end
  endtask

  task automatic put(input int s, input int k, input logic [1:0] o, input int c, input int l);
    pop[s][k] = o; pc[s][k] = c; pl[s][k] = l;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start0 = 1'b0; start1 = 1'b0;
    step(); step(); step();
    idx[0] = 3'd0; idx[1] = 3'd0; took[0] = 1'b0; took[1] = 1'b0;
    rt0 = 0; rt1 = 0;
    rst_n = 1'b1;
  endtask

  task automatic pulse(input logic a, input logic b);
    start0 = a; start1 = b;
    step();
    start0 = 1'b0; start1 = 1'b0;
  endtask

  task automatic wait_take(input int q, output int t);
    int g = 0;
    while (!took[q] && g < 100) begin step(); g++; end
    if (g >= 100) chk("R1 take timeout", 0, 1);
    t = cyc;
  endtask

  task automatic wait_idle(input logic both);
    int g = 0;
    while (!(idle0 && (!both || idle1)) && g < 5000) begin step(); g++; end
    if (g >= 5000) chk("R8 idle timeout", 0, 1);
  endtask

  initial begin
    int t, n, l, w, g0, g1, mx;
    int nl[5] = '{1, 5, 16, 17, 33};
    int a0[4] = '{40, 3, 40, 8};
    int a1[4] = '{40, 40, 5, 8};
    bit fl;
    clear_prog();
    idx[0] = 3'd0; idx[1] = 3'd0; took[0] = 1'b0; took[1] = 1'b0;

    // R9 / R1: reset state, no consumption before start
    put(0, 0, DISP, 4, 2); put(1, 0, DISP, 4, 2);
    do_reset();
    step(); step(); step();
    chk("R9 busy", int'(slot_busy), 0);
    chk("R9 idle0", int'(idle0), 0);
    chk("R9 idle1", int'(idle1), 0);
    chk("R1 no take0 before start", int'(cmd0_take), 0);
    chk("R1 no take1 before start", int'(cmd1_take), 0);

    // R2 R5 R7 R8: single stream sweep
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 2; b++) begin
        n = nl[a]; l = (b != 0) ? 3 : 1;
        w = (n + NSLOT - 1) / NSLOT;
        clear_prog();
        put(0, 0, DISP, n, l); put(0, 1, ENDC, 0, 1);
        do_reset();
        pulse(1'b1, 1'b0);
        wait_take(0, t);
        step(); step();
        chk("R2 single-queue slots", qcount(0), (n < NSLOT) ? n : NSLOT);
        chk("R8 idle0 while busy", int'(idle0), 0);
        wait_idle(1'b0);
        chk("R5 drain cycles", cyc - t, w * (l + 1) + 1);
        chk("R7 retired q0", rt0, n);
      end

    // R2 R3 R7: both queues from an empty pool
    for (int a = 0; a < 4; a++) begin
      int bm, om;
      g0 = a0[a]; if (8 + ((a1[a] < 8) ? 8 - a1[a] : 0) < g0) g0 = 8 + ((a1[a] < 8) ? 8 - a1[a] : 0);
      g1 = (a1[a] < NSLOT - g0) ? a1[a] : NSLOT - g0;
      bm = (1 << (g0 + g1)) - 1;
      om = bm & ~((1 << g0) - 1);
      clear_prog();
      put(0, 0, DISP, a0[a], 5); put(0, 1, ENDC, 0, 1);
      put(1, 0, DISP, a1[a], 5); put(1, 1, ENDC, 0, 1);
      do_reset();
      pulse(1'b1, 1'b1);
      wait_take(0, t);
      chk("R1 both accept together", int'(took[1]), 1);
      step(); step();
      chk("R3 busy map", int'(slot_busy), bm);
      chk("R2 owner map", int'(slot_owner), om);
      wait_idle(1'b1);
      chk("R7 retired q0", rt0, a0[a]);
      chk("R7 retired q1", rt1, a1[a]);
    end

    // R4: odd split alternates, R1: dispatch waits for empty queue
    clear_prog();
    put(0, 0, DISP, 1, 50); put(0, 1, DISP, 40, 2); put(0, 2, ENDC, 0, 1);
    put(1, 0, DISP, 40, 2); put(1, 1, ENDC, 0, 1);
    do_reset();
    pulse(1'b1, 1'b1);
    wait_take(0, t);
    step();
    chk("R1 dispatch held while queued", int'(took[0]), 0);
    step();
    chk("R1 dispatch taken when queue empty", int'(took[0]), 1);
    step(); step(); step();
    chk("R4 first odd split q0", qcount(0), 9);
    chk("R4 first odd split q1", qcount(1), 7);
    step(); step(); step();
    chk("R4 second odd split q0", qcount(0), 8);
    chk("R4 second odd split q1", qcount(1), 8);
    wait_idle(1'b1);
    chk("R8 idle0 end", int'(idle0), 1);

    // R6: flush on stream 0 while stream 1 keeps running
    clear_prog();
    put(0, 0, DISP, 16, 10); put(0, 1, FLSH, 0, 1); put(0, 2, DISP, 4, 3); put(0, 3, ENDC, 0, 1);
    put(1, 0, DISP, 40, 4); put(1, 1, ENDC, 0, 1);
    do_reset();
    pulse(1'b1, 1'b1);
    wait_take(0, t);
    mx = 0; fl = 1'b0;
    for (int g = 0; g < 500 && !fl; g++) begin
      step();
      if (idx[0] == 3'd2 && qcount(1) > mx) mx = qcount(1);
      if (took[0] && idx[0] == 3'd2) begin
        fl = 1'b1;
        chk("R6 barrier releases after own threads", rt0, 16);
        chk("R6 other stream ran during wait", int'(mx > 0), 1);
      end
    end
    if (!fl) chk("R6 post-barrier dispatch taken", 0, 1);
    wait_idle(1'b1);
    chk("R7 retired q0 after flush", rt0, 20);
    chk("R7 retired q1 after flush", rt1, 40);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule